// File: doc/BRIEF.md
# Twelve-Hour BCD Time Counter

This block keeps the time of day in twelve-hour form. It runs entirely from the 32.768 kHz crystal clock. A binary prescaler turns that rate into one enable pulse per second. The pulse steps a cascade of decimal digits: the seconds units and tens, the minutes units and tens, and an hours field that runs from 1 to 12. An AM/PM flag sits above the hours field.

Every register shares the crystal clock. A stage moves only in a cycle where the second pulse is high and every lower stage sits at its terminal value, so the counter has no ripple clocking. Two set inputs step the minutes field or the hours field by one per clock while they are held, so the time can be adjusted. The outputs go straight to a display driver, which is outside this block.

Top module: `tod_clock_chain`

## Requirements
- R1: A synchronous reset loads 12:00:00 with the AM/PM flag low (low means AM) and clears the prescaler.
- R2: With a prescale ratio of PRESCALE_DIV, tick_o is high for one clock in every PRESCALE_DIV clocks. After reset is released, its first high cycle is clock number PRESCALE_DIV.
- R3: The seconds units digit steps by one at the clock edge that ends each tick_o cycle. It goes 0 to 9, then returns to 0. It holds its value in every other cycle.
- R4: The seconds tens digit steps once each time the units digit wraps from 9. It goes 0 to 5, then returns to 0.
- R5: The minutes units digit (0 to 9) and the minutes tens digit (0 to 5) step when a tick arrives while the seconds read 59, and they carry between each other in the same way as the seconds digits.
- R6: The hours field is a single tens bit plus a BCD units digit, so 12 reads as tens=1, units=2. It steps when a tick arrives at mm:ss 59:59. It goes 09 to 10 and 12 to 01, and it never reads 00 or more than 12.
- R7: The AM/PM flag inverts only on the step from 11:59:59 to 12:00:00. The step from 12:59:59 to 01:00:00 leaves it unchanged.
- R8: Each clock with set_min_i high steps the minutes field by one, and 59 goes to 00. This never changes the hours field, and the seconds keep running.
- R9: Each clock with set_hr_i high steps the hours field by one, and 12 goes to 01. The AM/PM flag does not change, even on the step from 11 to 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal clock; every register samples on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| set_min_i | input | 1 | Steps the minutes field once per clock while high |
| set_hr_i | input | 1 | Steps the hours field once per clock while high |
| tick_o | output | 1 | One-per-second enable pulse |
| sec_ones_o | output | 4 | Seconds units digit, BCD |
| sec_tens_o | output | 4 | Seconds tens digit, BCD |
| min_ones_o | output | 4 | Minutes units digit, BCD |
| min_tens_o | output | 4 | Minutes tens digit, BCD |
| hr_ones_o | output | 4 | Hours units digit, BCD |
| hr_tens_o | output | 1 | Hours tens bit |
| pm_o | output | 1 | AM/PM flag, high for PM |

## Verification
The bench builds the counter with PRESCALE_DIV set to 4. One second then lasts four clocks, and a whole hour of counting fits in about 14,400 cycles. This puts the 59-to-00 minute carry, the 12-to-01 hours roll and the 11:59:59 AM/PM change within a short run. The set inputs carry the hours field to 11 and the minutes to 59 in a few dozen clocks. Because the prescaler ratio is small, the bench can also predict the exact seconds value after every set burst.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(DIV - 1));
  assign tick_o = last;

  always_ff @(posedge clk_i) begin
    if (rst_i)     cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  if (DIV > 1) begin : g_chk
    // R2: a tick lasts exactly one clock
    assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/tod_digit.sv
module tod_digit
  import tod_pkg::*;
#(
  parameter int LIMIT = 9
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  output bcd_t val_o,
  output logic at_limit_o
);
  bcd_t val_q;

  assign at_limit_o = (val_q == DIGIT_W'(LIMIT));
  assign val_o      = val_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)           val_q <= '0;
    else if (adv_i) begin
      if (at_limit_o)    val_q <= '0;
      else               val_q <= val_q + 1'b1;
    end
  end

  // R3: a digit stays inside its decimal range
  assert_digit_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    val_q <= DIGIT_W'(LIMIT));
  // R3: without an advance the digit holds
  assert_digit_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(val_q));
endmodule

// File: rtl/tod_hours.sv
module tod_hours
  import tod_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic carry_i,
  output logic tens_o,
  output bcd_t units_o,
  output logic pm_o
);
  logic tens_q, pm_q, step, is_eleven;
  bcd_t units_q;

  assign step      = set_i | carry_i;
  assign is_eleven = tens_q && (units_q == 4'd1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tens_q  <= 1'b1;
      units_q <= 4'd2;
      pm_q    <= 1'b0;
    end else begin
      if (step) begin
        if (tens_q && units_q == 4'd2) begin
          tens_q  <= 1'b0;
          units_q <= 4'd1;
        end else if (units_q == 4'd9) begin
          tens_q  <= 1'b1;
          units_q <= 4'd0;
        end else begin
          units_q <= units_q + 1'b1;
        end
      end
      if (carry_i && !set_i && is_eleven) pm_q <= ~pm_q;
    end
  end

  assign tens_o  = tens_q;
  assign units_o = units_q;
  assign pm_o    = pm_q;

  // R6: the hours field reads 1..12
  assert_hour_range_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (tens_q ? (units_q <= 4'd2) : (units_q != 4'd0 && units_q <= 4'd9)));
  // R7: the flag changes only when the field has just become 12
  assert_pm_at_noon_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(pm_q) |-> (tens_q && units_q == 4'd2));
  // R9: setting the hours never touches the flag
  assert_set_keeps_pm_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> $stable(pm_q));
endmodule

// File: rtl/tod_clock_chain.sv
module tod_clock_chain
  import tod_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       set_min_i,
  input  logic       set_hr_i,
  output logic       tick_o,
  output logic [3:0] sec_ones_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_ones_o,
  output logic [3:0] min_tens_o,
  output logic [3:0] hr_ones_o,
  output logic       hr_tens_o,
  output logic       pm_o
);
  localparam int NDIG = 4;

  logic            tick;
  logic [NDIG-1:0] adv;
  logic [NDIG-1:0] tc;
  bcd_t            dv [NDIG];
  logic            hr_carry;

  tod_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tick_o(tick)
  );

  assign adv[0]   = tick;
  assign adv[1]   = tick & tc[0];
  assign adv[2]   = set_min_i | (tick & tc[0] & tc[1]);
  assign adv[3]   = adv[2] & tc[2];
  assign hr_carry = tick & (&tc) & ~set_min_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    localparam int LIM = (g % 2 == 0) ? 9 : 5;
    tod_digit #(.LIMIT(LIM)) u_dig (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .adv_i     (adv[g]),
      .val_o     (dv[g]),
      .at_limit_o(tc[g])
    );
  end

  tod_hours u_hours (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (set_hr_i),
    .carry_i(hr_carry),
    .tens_o (hr_tens_o),
    .units_o(hr_ones_o),
    .pm_o   (pm_o)
  );

  assign tick_o     = tick;
  assign sec_ones_o = dv[0];
  assign sec_tens_o = dv[1];
  assign min_ones_o = dv[2];
  assign min_tens_o = dv[3];

  // R8: a minute set alone leaves the hours field alone
  assert_setmin_no_hour_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_min_i && !set_hr_i) |=> $stable({hr_tens_o, hr_ones_o}));
  // R5: the minutes units digit moves only on a set or a seconds roll
  assert_min_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!set_min_i && !(tick && sec_tens_o == 4'd5 && sec_ones_o == 4'd9))
      |=> $stable(min_ones_o));
endmodule

// File: tb/tod_clock_chain_tb.sv
`timescale 1ns/1ps
module tod_clock_chain_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_min = 1'b0;
  logic set_hr = 1'b0;
  logic tick, hr_tens, pm;
  logic [3:0] s1, s10, m1, m10, h1;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tod_clock_chain #(.PRESCALE_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_i(rst), .set_min_i(set_min), .set_hr_i(set_hr),
    .tick_o(tick), .sec_ones_o(s1), .sec_tens_o(s10), .min_ones_o(m1),
    .min_tens_o(m10), .hr_ones_o(h1), .hr_tens_o(hr_tens), .pm_o(pm)
  );

  function automatic logic [23:0] now_hex();
    return {3'b000, hr_tens, h1, m10, m1, s10, s1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam int STEP_CYC [NV] = '{32, 4, 196, 4, 14156, 4};
  localparam logic [23:0] EXP_T [NV] =
    '{24'h120009, 24'h120010, 24'h120059, 24'h120100, 24'h125959, 24'h010000};

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 reset time", {7'd0, now_hex(), pm}, {7'd0, 24'h120000, 1'b0});
    chk("R1 reset tick", tick, 0);
    rst = 1'b0;
    step(2);
    chk("R2 no early tick", tick, 0);
    step(1);
    chk("R2 first tick", tick, 1);
    step(1);
    chk("R2 tick single", tick, 0);
    chk("R3 first second", now_hex(), 24'h120001);

    for (int i = 0; i < NV; i++) begin
      step(STEP_CYC[i]);
      chk("R3/R4/R5/R6 vector", {7'd0, now_hex(), pm}, {7'd0, EXP_T[i], 1'b0});
    end

    set_hr = 1'b1; step(8);
    chk("R9 set to 09", now_hex(), 24'h090002);
    step(1);
    chk("R6 09 to 10", now_hex(), 24'h100002);
    step(2);
    chk("R9 set to 12 keeps AM", {now_hex(), pm}, {24'h120002, 1'b0});
    step(1);
    chk("R9 12 to 01", now_hex(), 24'h010003);
    step(10);
    set_hr = 1'b0;
    chk("R9 set to 11", {now_hex(), pm}, {24'h110005, 1'b0});

    set_min = 1'b1; step(59); set_min = 1'b0;
    chk("R8 minutes to 59", now_hex(), 24'h115920);

    for (int k = 0; k < 400; k++) begin
      if (tick && s10 == 4'd5 && s1 == 4'd9) break;
      step(1);
    end
    chk("R7 11:59:59 still AM", {now_hex(), pm}, {24'h115959, 1'b0});
    step(1);
    chk("R7 noon sets PM", {now_hex(), pm}, {24'h120000, 1'b1});
    step(14400);
    chk("R7 12 to 01 keeps PM", {now_hex(), pm}, {24'h010000, 1'b1});

    set_min = 1'b1; step(59);
    chk("R8 set 59 seconds run", now_hex(), 24'h015914);
    step(1); set_min = 1'b0;
    chk("R8 59 to 00 no hour carry", {now_hex(), pm}, {24'h010015, 1'b1});

    @(negedge clk); rst = 1'b1;
    step(1); rst = 1'b0;
    chk("R1 reset mid-run", {7'd0, now_hex(), pm, tick}, {6'd0, 24'h120000, 1'b0, 1'b0});
    step(3);
    chk("R2 tick after reset", tick, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule